// File: doc/BRIEF.md
# DMA Channel Control Register File and Fixed-Priority Arbiter

This block holds the per-channel control state of a multi-channel DMA controller and picks which channel the transfer engines serve next. Software reaches it through a simple single-cycle register port. Five per-channel control bits each have two addresses, one for setting and one for clearing: enable, alternate-descriptor select, high priority, burst-only and request mask. Because of this, one channel can be changed without a read-modify-write. The same port also gives a software request strobe, a flag register holding one done bit per channel plus a bus error bit, a write-1-to-clear flag address, an interrupt enable register and a global enable.

Peripherals raise single or burst requests. Engines report the end of a granted transaction and the completion of a channel's whole cycle. A channel can be granted only when all of these hold: it is enabled, it has a pending request, that request is not masked, and the global enable is on. Among the eligible channels, the high-priority group is served first, and inside a group the lowest channel number wins. A grant is held until the engine signals the end of the transaction. The interrupt line is the OR of all flags gated by their enables.

Top module: `dmactl_arb`

## Requirements
- R1: After reset every register reads 0, `grant_o` and `alt_sel_o` are 0 and `irq_o` is low.
- R2: Register map (4-bit word address): 0 global config (bit 0 = global enable, read/write); enable set 1 / clear 2; alternate set 3 / clear 4; high priority set 5 / clear 6; burst-only set 7 / clear 8; mask set 9 / clear 10; software request 11 (write only, reads 0); flags 12 (channel c done at bit c, bus error at bit 31); flag clear 13; interrupt enable 14 (same layout as flags). Writing 1 to bit c of a set or clear address changes only channel c. Bits at or above the channel count are ignored. Reading either address of a pair returns the current state.
- R3: `alt_sel_o` bit c equals the channel's alternate bit: 1 selects the alternate descriptor, 0 the primary one.
- R4: A channel is eligible only when it is enabled, has a pending request, is not masked and the global enable is set. A request written while any of these is missing stays pending.
- R5: Eligible high-priority channels win over default ones. Inside a group the lowest index wins. At most one grant bit is set.
- R6: When no grant is held, the winner is granted at the next clock edge and its pending request is consumed. The grant holds until the edge that samples `xfer_end_i` high, at which it drops to 0.
- R7: Writing 1 to bit c of the software request address makes channel c pending.
- R8: A channel with burst-only set ignores `sreq_i` and becomes pending only from `breq_i`. With burst-only clear, either request makes it pending.
- R9: Setting a mask bit does not cut a grant already held. The masked channel is not granted again until the mask is cleared.
- R10: `done_i` bit c clears channel c's enable and sets its done flag at the same edge. This takes precedence over an enable-set write in that cycle.
- R11: `bus_err_i` sets flag bit 31. Writing 1 to a bit of the flag clear address clears that flag. A new event in the same cycle wins over the clear.
- R12: `irq_o` is high exactly when some flag bit and its matching interrupt enable bit are both 1.
- R13: With the global enable clear, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| sreq_i | input | NUM_CH | Single requests from peripherals |
| breq_i | input | NUM_CH | Burst requests from peripherals |
| done_i | input | NUM_CH | Cycle-complete pulses from the engines |
| xfer_end_i | input | 1 | End of the currently granted transaction |
| bus_err_i | input | 1 | Bus error pulse |
| grant_o | output | NUM_CH | One-hot grant to the channel engines |
| alt_sel_o | output | NUM_CH | Per-channel alternate descriptor select |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bit in the control state shows up at the ports quickly. A bad enable, mask or priority bit causes a grant to the wrong channel, or no grant at all, within two clocks of the request. A lost or duplicated pending bit shows as a missing or repeated grant after the next transaction end. Flag and interrupt-enable errors show on `irq_o` and on the flag readback in the cycle after the event. For these reasons the bench checks grant order across mixed priority groups, holds a grant through mask changes, and reads the set/clear pairs back after each write.

// File: rtl/dmactl_arb.sv
module dmactl_arb #(
  parameter int NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] sreq_i,
  input  logic [NUM_CH-1:0] breq_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic              xfer_end_i,
  input  logic              bus_err_i,
  output logic [NUM_CH-1:0] grant_o,
  output logic [NUM_CH-1:0] alt_sel_o,
  output logic              irq_o
);
  // NUM_CH must stay within 1..30 so bit 31 is free for the error flag
  localparam int PADW = 32 - NUM_CH;
  localparam int GAPW = 31 - NUM_CH;
  localparam logic [3:0] A_CFG  = 4'd0,  A_ENS  = 4'd1,  A_ENC  = 4'd2;
  localparam logic [3:0] A_ALS  = 4'd3,  A_ALC  = 4'd4,  A_PRS  = 4'd5;
  localparam logic [3:0] A_PRC  = 4'd6,  A_BSS  = 4'd7,  A_BSC  = 4'd8;
  localparam logic [3:0] A_MKS  = 4'd9,  A_MKC  = 4'd10, A_SWR  = 4'd11;
  localparam logic [3:0] A_FLG  = 4'd12, A_FLC  = 4'd13, A_IEN  = 4'd14;

  logic              gen_q, err_q, eie_q;
  logic [NUM_CH-1:0] en_q, alt_q, pri_q, bst_q, msk_q, pend_q, flg_q, ien_q, grant_q;
  logic [NUM_CH-1:0] wbits, elig, hi, pool, win, take, newreq;

  assign wbits = reg_wdata[NUM_CH-1:0];

  function automatic logic [NUM_CH-1:0] hit(input logic we, input logic [3:0] addr,
                                            input logic [3:0] sel, input logic [NUM_CH-1:0] d);
    return (we && addr == sel) ? d : '0;
  endfunction

  function automatic logic [NUM_CH-1:0] setclr(input logic [NUM_CH-1:0] cur,
                                               input logic [NUM_CH-1:0] s,
                                               input logic [NUM_CH-1:0] c);
    return (cur | s) & ~c;
  endfunction

  assign elig = en_q & pend_q & ~msk_q & {NUM_CH{gen_q}};
  assign hi   = elig & pri_q;
  assign pool = (|hi) ? hi : elig;
  assign win  = pool & (~pool + 1'b1);
  assign take = (|grant_q) ? '0 : win;
  assign newreq = hit(reg_we, reg_addr, A_SWR, wbits) | breq_i | (sreq_i & ~bst_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= 1'b0;
      err_q   <= 1'b0;
      eie_q   <= 1'b0;
      en_q    <= '0;
      alt_q   <= '0;
      pri_q   <= '0;
      bst_q   <= '0;
      msk_q   <= '0;
      pend_q  <= '0;
      flg_q   <= '0;
      ien_q   <= '0;
      grant_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_CFG) gen_q <= reg_wdata[0];
      if (reg_we && reg_addr == A_IEN) begin
        ien_q <= wbits;
        eie_q <= reg_wdata[31];
      end
      en_q  <= setclr(en_q, hit(reg_we, reg_addr, A_ENS, wbits),
                      hit(reg_we, reg_addr, A_ENC, wbits) | done_i);
      alt_q <= setclr(alt_q, hit(reg_we, reg_addr, A_ALS, wbits), hit(reg_we, reg_addr, A_ALC, wbits));
      pri_q <= setclr(pri_q, hit(reg_we, reg_addr, A_PRS, wbits), hit(reg_we, reg_addr, A_PRC, wbits));
      bst_q <= setclr(bst_q, hit(reg_we, reg_addr, A_BSS, wbits), hit(reg_we, reg_addr, A_BSC, wbits));
      msk_q <= setclr(msk_q, hit(reg_we, reg_addr, A_MKS, wbits), hit(reg_we, reg_addr, A_MKC, wbits));
      pend_q <= (pend_q & ~take) | newreq;
      flg_q  <= (flg_q & ~hit(reg_we, reg_addr, A_FLC, wbits)) | done_i;
      err_q  <= (err_q & ~(reg_we && reg_addr == A_FLC && reg_wdata[31])) | bus_err_i;
      if (|grant_q) begin
        if (xfer_end_i) grant_q <= '0;
      end else begin
        grant_q <= win;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG:        reg_rdata = {31'd0, gen_q};
      A_ENS, A_ENC: reg_rdata = {{PADW{1'b0}}, en_q};
      A_ALS, A_ALC: reg_rdata = {{PADW{1'b0}}, alt_q};
      A_PRS, A_PRC: reg_rdata = {{PADW{1'b0}}, pri_q};
      A_BSS, A_BSC: reg_rdata = {{PADW{1'b0}}, bst_q};
      A_MKS, A_MKC: reg_rdata = {{PADW{1'b0}}, msk_q};
      A_FLG, A_FLC: reg_rdata = {err_q, {GAPW{1'b0}}, flg_q};
      A_IEN:        reg_rdata = {eie_q, {GAPW{1'b0}}, ien_q};
      default:      reg_rdata = 32'd0;
    endcase
  end

  assign grant_o   = grant_q;
  assign alt_sel_o = alt_q;
  assign irq_o     = (|(flg_q & ien_q)) | (err_q & eie_q);
endmodule

// File: rtl/dmactl_arb_chk.sv
module dmactl_arb_chk #(
  parameter int NUM_CH = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] grant_o,
  input logic              xfer_end_i,
  input logic [NUM_CH-1:0] done_i,
  input logic              bus_err_i,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] msk_q,
  input logic              gen_q,
  input logic [NUM_CH-1:0] flg_q,
  input logic              err_q
);
  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && !xfer_end_i) |=> grant_o == $past(grant_o));

  // R6
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && xfer_end_i) |=> grant_o == '0);

  // R4 R13
  grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0) |=> (grant_o == '0) ||
      ($past(gen_q) && (($past(en_q & ~msk_q) & grant_o) != '0)));

  // R10
  done_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i != '0) |=> ((en_q & $past(done_i)) == '0) &&
                       ((flg_q & $past(done_i)) == $past(done_i)));

  // R11
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_i |=> err_q);
endmodule

bind dmactl_arb dmactl_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant_o(grant_o), .xfer_end_i(xfer_end_i),
  .done_i(done_i), .bus_err_i(bus_err_i), .en_q(en_q), .msk_q(msk_q),
  .gen_q(gen_q), .flg_q(flg_q), .err_q(err_q)
);

// File: tb/dmactl_arb_tb.sv
module dmactl_arb_tb;
  localparam int NCH = 12;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {write addr, write data, read addr, expected read}
  localparam logic [71:0] VEC [NVEC] = '{
    {4'd1,  32'h0000_000F, 4'd1,  32'h0000_000F},
    {4'd2,  32'h0000_0005, 4'd1,  32'h0000_000A},
    {4'd1,  32'h0000_0800, 4'd2,  32'h0000_080A},
    {4'd1,  32'h0000_F000, 4'd1,  32'h0000_080A},
    {4'd3,  32'h0000_00F0, 4'd3,  32'h0000_00F0},
    {4'd4,  32'h0000_0010, 4'd4,  32'h0000_00E0},
    {4'd5,  32'h0000_0300, 4'd5,  32'h0000_0300},
    {4'd6,  32'h0000_0100, 4'd5,  32'h0000_0200},
    {4'd7,  32'h0000_000C, 4'd7,  32'h0000_000C},
    {4'd8,  32'h0000_0008, 4'd8,  32'h0000_0004},
    {4'd9,  32'h0000_0003, 4'd9,  32'h0000_0003},
    {4'd10, 32'h0000_0001, 4'd9,  32'h0000_0002},
    {4'd14, 32'h8000_0FFF, 4'd14, 32'h8000_0FFF},
    {4'd0,  32'h0000_0001, 4'd0,  32'h0000_0001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] sreq_i = '0, breq_i = '0, done_i = '0;
  logic xfer_end_i = 1'b0, bus_err_i = 1'b0;
  logic [NCH-1:0] grant_o, alt_sel_o;
  logic irq_o;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmactl_arb #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sreq_i(sreq_i),
    .breq_i(breq_i), .done_i(done_i), .xfer_end_i(xfer_end_i),
    .bus_err_i(bus_err_i), .grant_o(grant_o), .alt_sel_o(alt_sel_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_grant(input string req, input logic [NCH-1:0] exp);
    for (int i = 0; i < 6; i++) begin
      if (grant_o != '0) break;
      @(negedge clk);
    end
    check(req, 32'(grant_o), 32'(exp));
  endtask

  task automatic no_grant(input string req, input int n);
    logic [NCH-1:0] seen = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seen |= grant_o;
    end
    check(req, 32'(seen), 32'd0);
  endtask

  task automatic end_xfer(input string req);
    @(negedge clk);
    xfer_end_i = 1'b1;
    @(negedge clk);
    xfer_end_i = 1'b0;
    check(req, 32'(grant_o), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R1 reset state
    for (int a = 0; a < 16; a++) rd_check("R1 reset read", 4'(a), 32'd0);
    check("R1 grant", 32'(grant_o), 32'd0);
    check("R1 alt", 32'(alt_sel_o), 32'd0);
    check("R1 irq", 32'(irq_o), 32'd0);

    // R2 set/clear register table
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][71:68], VEC[i][67:36]);
      rd_check($sformatf("R2 vector %0d", i), VEC[i][35:32], VEC[i][31:0]);
    end
    rd_check("R2 swreq reads zero", 4'd11, 32'd0);
    // R3
    check("R3 alt select", 32'(alt_sel_o), 32'h0E0);

    do_reset();
    rd_check("R1 reset after use", 4'd1, 32'd0);

    // R13 and R7: request pending but global enable off
    wr(4'd1, 32'h001);
    wr(4'd11, 32'h001);
    no_grant("R13 no grant without global enable", 4);
    wr(4'd0, 32'h1);
    wait_grant("R7 software request grant", 12'h001);
    end_xfer("R6 grant drops on end");
    // R10
    @(negedge clk); done_i = 12'h001;
    @(negedge clk); done_i = '0;
    rd_check("R10 enable cleared", 4'd1, 32'd0);
    rd_check("R10 done flag set", 4'd12, 32'h001);
    check("R12 irq masked", 32'(irq_o), 32'd0);
    wr(4'd14, 32'h001);
    check("R12 irq raised", 32'(irq_o), 32'd1);
    wr(4'd13, 32'h001);
    rd_check("R11 flag cleared", 4'd12, 32'd0);
    check("R12 irq cleared", 32'(irq_o), 32'd0);

    // R5 priority ordering
    wr(4'd1, 32'h0F0);
    wr(4'd5, 32'h0A0);
    wr(4'd11, 32'h0F0);
    wait_grant("R5 first high group", 12'h020);
    @(negedge clk);
    check("R6 grant held", 32'(grant_o), 32'h020);
    end_xfer("R6 end 1");
    wait_grant("R5 second high group", 12'h080);
    end_xfer("R6 end 2");
    wait_grant("R5 lowest default", 12'h010);
    end_xfer("R6 end 3");
    wait_grant("R5 last default", 12'h040);
    end_xfer("R6 end 4");
    no_grant("R6 requests consumed", 3);

    // R4 enable required
    wr(4'd11, 32'h100);
    no_grant("R4 disabled channel not granted", 3);
    wr(4'd1, 32'h100);
    wait_grant("R4 pending kept until enabled", 12'h100);
    end_xfer("R6 end 5");

    // R9 mask
    wr(4'd1, 32'h600);
    wr(4'd11, 32'h200);
    wait_grant("R9 channel 9 granted", 12'h200);
    wr(4'd9, 32'h600);
    wr(4'd11, 32'h600);
    check("R9 grant not cut by mask", 32'(grant_o), 32'h200);
    end_xfer("R9 end");
    no_grant("R9 masked channels blocked", 4);
    wr(4'd10, 32'h400);
    wait_grant("R9 unmasked channel 10", 12'h400);
    end_xfer("R9 end 2");
    wr(4'd10, 32'h200);
    wait_grant("R9 unmasked channel 9", 12'h200);
    end_xfer("R9 end 3");

    // R8 burst-only
    wr(4'd1, 32'h006);
    wr(4'd7, 32'h002);
    @(negedge clk); sreq_i = 12'h002;
    @(negedge clk); sreq_i = '0;
    no_grant("R8 single request ignored", 3);
    @(negedge clk); breq_i = 12'h002;
    @(negedge clk); breq_i = '0;
    wait_grant("R8 burst request served", 12'h002);
    end_xfer("R8 end");
    @(negedge clk); sreq_i = 12'h004;
    @(negedge clk); sreq_i = '0;
    wait_grant("R8 single request on normal channel", 12'h004);
    end_xfer("R8 end 2");

    // R11/R12 bus error
    @(negedge clk); bus_err_i = 1'b1;
    @(negedge clk); bus_err_i = 1'b0;
    rd_check("R11 error flag", 4'd12, 32'h8000_0000);
    check("R12 error irq disabled", 32'(irq_o), 32'd0);
    wr(4'd14, 32'h8000_0000);
    check("R12 error irq", 32'(irq_o), 32'd1);
    // R11: event wins over same-cycle clear
    @(negedge clk);
    bus_err_i = 1'b1; reg_we = 1'b1; reg_addr = 4'd13; reg_wdata = 32'h8000_0000;
    @(negedge clk);
    bus_err_i = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    rd_check("R11 set wins over clear", 4'd12, 32'h8000_0000);
    wr(4'd13, 32'h8000_0000);
    rd_check("R11 error cleared", 4'd12, 32'd0);

    // R10: done wins over same-cycle enable set
    @(negedge clk);
    done_i = 12'h008; reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h008;
    @(negedge clk);
    done_i = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(4'd1, d);
    check("R10 done over enable set", d & 32'h008, 32'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule